// File: doc/BRIEF.md
# 128-bit Sticky Right Shifter

This unit moves a 128-bit word, given as an upper and a lower 64-bit half, toward the least significant end by a count from 0 to 255. It does not drop the bits that fall off the bottom. Their OR is merged into bit 0 of the result. A rounding stage further down the datapath can then still tell that nonzero bits were lost. A count at or beyond the word width leaves only that single sticky bit. The unit is meant for the operand alignment shift and the final narrowing shift of a fused multiply-add pipeline. It makes no arithmetic or rounding decisions of its own.

A parameter selects one of two variants. The registered variant captures a result when the input valid is high and presents it one clock later with a matching valid. The combinational variant presents the result and the valid in the same cycle as the inputs. The shift itself is a logarithmic chain of stages, one per count bit. Each stage notes whether the bits it discards are nonzero.

Top module: `sticky_shift128`

## Requirements
- R1: For a count of 128 to 255, the upper output half is zero. The lower half is 1 if any of the 128 input bits was set and 0 otherwise.
- R2: For a count of exactly 64, the upper output half is zero. The lower half equals the old upper half, with bit 0 also set when the old lower half was nonzero.
- R3: For a count of 65 to 127, the upper output half is zero. The lower half is the old upper half shifted right by the count minus 64. Bit 0 is also set when any discarded upper-half bit or any lower-half bit was nonzero.
- R4: For a count of 1 to 63, the upper half is shifted right by the count. The lower half holds the lower half shifted right, with the low upper-half bits filling its top. Bit 0 is also set when any bit shifted out of the lower half was nonzero.
- R5: A count of 0 passes both halves through unchanged and adds no sticky bit.
- R6: The 128-bit result is nonzero exactly when the 128-bit input is nonzero.
- R7: With the registered variant (parameter REG_OUT=1), validOut is high exactly one clock after validIn was high. The outputs then carry the result for the inputs presented with that validIn.
- R8: A synchronous active-high rst clears validOut at the next rising clock edge.
- R9: In the registered variant, hiOut and loOut keep their value across every clock edge at which validIn is low.
- R10: With REG_OUT=0, validOut follows validIn and the result appears in the same cycle as its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| validIn | input | 1 | Inputs carry an operation this cycle |
| hiIn | input | 64 | Upper half of the word to shift |
| loIn | input | 64 | Lower half of the word to shift |
| shiftAmt | input | 8 | Right shift count; 128 and above shifts everything out |
| validOut | output | 1 | Outputs carry a result |
| hiOut | output | 64 | Upper half of the shifted word |
| loOut | output | 64 | Lower half of the shifted word, sticky bit merged into bit 0 |

## Verification
The bench builds two instances with the default widths (64-bit halves, 8-bit count). One has REG_OUT=1 and the other REG_OUT=0. Both receive the same inputs, so every operation is checked through the one-clock captured path and through the same-cycle path. With the 8-bit count every stage of the chain can be reached, including the top stage, whose step equals the full word and flushes everything into the sticky bit. The counts 63, 64, 65, 127, 128 and 255 are therefore driven with both dense and sparse data, so the sticky term is sometimes set and sometimes clear.

// File: rtl/sticky_shift_pkg.sv
package sticky_shift_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic capture;   // load the shifted word into the result register
    logic outValid;  // the result register holds a live result
  } shiftStrobes_t;

endpackage

// File: rtl/sticky_shift_ctrl.sv
module sticky_shift_ctrl
  import sticky_shift_pkg::*;
#(
  parameter int REG_OUT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          validIn,
  output shiftStrobes_t strobes,
  output logic          validOut
);

  generate
    if (REG_OUT != 0) begin : g_reg
      logic validQ;

      always_ff @(posedge clk) begin
        if (rst) validQ <= 1'b0;
        else     validQ <= validIn;
      end

      assign strobes.capture  = validIn;
      assign strobes.outValid = validQ;
      assign validOut         = validQ;

      // R7: a result follows each accepted input after one clock
      p_latency_r7: assert property (@(posedge clk) disable iff (rst)
        validIn |=> validOut);
      // R7: no result appears without an input
      p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !validIn |=> !validOut);
      // R8: reset clears the output valid
      p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> !validOut);
    end else begin : g_comb
      assign strobes.capture  = validIn;
      assign strobes.outValid = validIn;
      assign validOut         = validIn;
    end
  endgenerate

endmodule

// File: rtl/sticky_shift_dp.sv
module sticky_shift_dp
  import sticky_shift_pkg::*;
#(
  parameter int HALF_W  = 64,
  parameter int CNT_W   = 8,
  parameter int REG_OUT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  shiftStrobes_t     strobes,
  input  logic [HALF_W-1:0] hiIn,
  input  logic [HALF_W-1:0] loIn,
  input  logic [CNT_W-1:0]  shiftAmt,
  output logic [HALF_W-1:0] hiOut,
  output logic [HALF_W-1:0] loOut
);

  localparam int W = 2 * HALF_W;

  // One stage per count bit: stage k shifts by 2**k when that bit is set
  logic [W-1:0] stageVal [CNT_W+1];
  logic [CNT_W:0] stageSticky;
  logic [W-1:0] shifted;

  assign stageVal[0]    = {hiIn, loIn};
  assign stageSticky[0] = 1'b0;

  generate
    for (genvar k = 0; k < CNT_W; k++) begin : g_stage
      localparam longint STEP = 64'(1) << k;
      if (STEP >= W) begin : g_flush
        // step covers the whole word: every bit goes to the sticky term
        assign stageVal[k+1]    = shiftAmt[k] ? '0 : stageVal[k];
        assign stageSticky[k+1] = stageSticky[k] | (shiftAmt[k] & (|stageVal[k]));
      end else begin : g_step
        assign stageVal[k+1]    = shiftAmt[k] ? (stageVal[k] >> STEP) : stageVal[k];
        assign stageSticky[k+1] = stageSticky[k] | (shiftAmt[k] & (|stageVal[k][STEP-1:0]));
      end
    end
  endgenerate

  assign shifted = stageVal[CNT_W] | {{(W-1){1'b0}}, stageSticky[CNT_W]};

  generate
    if (REG_OUT != 0) begin : g_reg
      logic [W-1:0] resQ;

      always_ff @(posedge clk) begin
        if (rst)                  resQ <= '0;
        else if (strobes.capture) resQ <= shifted;
      end

      assign hiOut = resQ[W-1:HALF_W];
      assign loOut = resQ[HALF_W-1:0];

      // R1: a full shift-out leaves at most the sticky bit
      p_full_out_r1: assert property (@(posedge clk) disable iff (rst)
        strobes.capture && (32'(shiftAmt) >= W) |=> (hiOut == '0) && (loOut[HALF_W-1:1] == '0));
      // R2 and R3: counts of a half word or more clear the upper half
      p_hi_clear_r2: assert property (@(posedge clk) disable iff (rst)
        strobes.capture && (32'(shiftAmt) >= HALF_W) |=> hiOut == '0);
      // R5: zero count is a pass-through
      p_zero_pass_r5: assert property (@(posedge clk) disable iff (rst)
        strobes.capture && (shiftAmt == '0) |=> {hiOut, loOut} == $past({hiIn, loIn}));
      // R6: a nonzero input never collapses to zero
      p_nonzero_kept_r6: assert property (@(posedge clk) disable iff (rst)
        strobes.capture |=> (|{hiOut, loOut}) == $past(|{hiIn, loIn}));
      // R9: result holds while nothing is captured
      p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !strobes.capture |=> $stable({hiOut, loOut}));
      // R7: valid output only once a capture has happened
      p_valid_data_r7: assert property (@(posedge clk) disable iff (rst)
        strobes.capture |=> strobes.outValid);
    end else begin : g_comb
      assign hiOut = shifted[W-1:HALF_W];
      assign loOut = shifted[HALF_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/sticky_shift128.sv
module sticky_shift128
  import sticky_shift_pkg::*;
#(
  parameter int HALF_W  = 64,
  parameter int CNT_W   = 8,
  parameter int REG_OUT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              validIn,
  input  logic [HALF_W-1:0] hiIn,
  input  logic [HALF_W-1:0] loIn,
  input  logic [CNT_W-1:0]  shiftAmt,
  output logic              validOut,
  output logic [HALF_W-1:0] hiOut,
  output logic [HALF_W-1:0] loOut
);

  shiftStrobes_t strobes;

  sticky_shift_ctrl #(
    .REG_OUT(REG_OUT)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .validIn (validIn),
    .strobes (strobes),
    .validOut(validOut)
  );

  sticky_shift_dp #(
    .HALF_W (HALF_W),
    .CNT_W  (CNT_W),
    .REG_OUT(REG_OUT)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .hiIn    (hiIn),
    .loIn    (loIn),
    .shiftAmt(shiftAmt),
    .hiOut   (hiOut),
    .loOut   (loOut)
  );

endmodule

// File: tb/sticky_shift128_tb.sv
module sticky_shift128_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic validIn = 1'b0;
  logic [63:0] hiIn = '0;
  logic [63:0] loIn = '0;
  logic [7:0] shiftAmt = '0;
  logic validOut, validOutC;
  logic [63:0] hiOut, loOut, hiOutC, loOutC;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sticky_shift128 #(.REG_OUT(1)) u_dut (
    .clk(clk), .rst(rst), .validIn(validIn), .hiIn(hiIn), .loIn(loIn),
    .shiftAmt(shiftAmt), .validOut(validOut), .hiOut(hiOut), .loOut(loOut)
  );

  sticky_shift128 #(.REG_OUT(0)) u_comb (
    .clk(clk), .rst(rst), .validIn(validIn), .hiIn(hiIn), .loIn(loIn),
    .shiftAmt(shiftAmt), .validOut(validOutC), .hiOut(hiOutC), .loOut(loOutC)
  );

  // {hi, lo, count, expected hi, expected lo}
  localparam logic [263:0] VEC [NV] = '{
    {64'h0, 64'h1, 8'd0, 64'h0, 64'h1},
    {64'h1, 64'h0, 8'd64, 64'h0, 64'h1},
    {64'h0, 64'h3, 8'd1, 64'h0, 64'h1},
    {64'h8000_0000_0000_0000, 64'h0, 8'd127, 64'h0, 64'h1},
    {64'h10, 64'h0, 8'd65, 64'h0, 64'h8},
    {64'h0, 64'h1, 8'd128, 64'h0, 64'h1},
    {64'h0, 64'h0, 8'd255, 64'h0, 64'h0},
    {64'hF0, 64'h1, 8'd4, 64'hF, 64'h1},
    {64'h1, 64'h0, 8'd1, 64'h0, 64'h8000_0000_0000_0000},
    {64'hAB, 64'h5, 8'd64, 64'h0, 64'hAB},
    {64'h1234, 64'h0, 8'd0, 64'h1234, 64'h0},
    {64'h0, 64'h8000_0000_0000_0000, 8'd63, 64'h0, 64'h1}
  };

  localparam logic [7:0] EDGE_CNT [7] = '{8'd0, 8'd63, 8'd64, 8'd65, 8'd127, 8'd128, 8'd255};

  function automatic string reqTag(input logic [7:0] c);
    if (c == 8'd0)       return "R5";
    else if (c < 8'd64)  return "R4";
    else if (c == 8'd64) return "R2";
    else if (c < 8'd128) return "R3";
    else                 return "R1";
  endfunction

  // Reference: whole-word shift plus OR of everything discarded
  function automatic logic [127:0] refShift(input logic [127:0] v, input int c);
    logic [127:0] r;
    logic lost;
    if (c >= 128) begin
      r = '0;
      lost = |v;
    end else begin
      r = v >> c;
      lost = (c == 0) ? 1'b0 : |(v & ((128'd1 << c) - 128'd1));
    end
    r[0] = r[0] | lost;
    return r;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive one operation; check the same-cycle variant, then the registered one
  task automatic apply(input logic [63:0] h, input logic [63:0] l,
                       input logic [7:0] c, input logic [127:0] exp);
    @(negedge clk);
    hiIn = h; loIn = l; shiftAmt = c; validIn = 1'b1;
    #1;
    chk(reqTag(c), "R10 comb result", {hiOutC, loOutC}, exp);
    chk("R10", "comb valid", {127'b0, validOutC}, 128'd1);
    @(negedge clk);
    validIn = 1'b0;
    chk(reqTag(c), "R7 registered result", {hiOut, loOut}, exp);
    chk("R7", "registered valid", {127'b0, validOut}, 128'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [127:0] v;
    logic [7:0] c;
    // reset with validIn high: valid must stay low (R8)
    validIn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8", "valid during reset", {127'b0, validOut}, 128'd0);
    validIn = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R7", "idle valid after reset", {127'b0, validOut}, 128'd0);

    // table of hand-worked vectors (R1 R2 R3 R4 R5)
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][263:200], VEC[i][199:136], VEC[i][135:128], VEC[i][127:0]);
    end

    // hold check: no capture while validIn is low (R9)
    apply(64'hDEAD_BEEF_0000_0001, 64'h0123_4567_89AB_CDEF, 8'd12,
          refShift({64'hDEAD_BEEF_0000_0001, 64'h0123_4567_89AB_CDEF}, 12));
    hiIn = 64'hFFFF_FFFF_FFFF_FFFF; loIn = 64'h5555; shiftAmt = 8'd3;
    @(negedge clk);
    chk("R9", "hold value", {hiOut, loOut},
        refShift({64'hDEAD_BEEF_0000_0001, 64'h0123_4567_89AB_CDEF}, 12));
    chk("R7", "valid drops", {127'b0, validOut}, 128'd0);

    // boundary counts with dense and sparse random data (R6 via refShift)
    for (int e = 0; e < 7; e++) begin
      for (int n = 0; n < 20; n++) begin
        v = {$urandom, $urandom, $urandom, $urandom};
        if (n[0]) v = v >> ($urandom % 128);
        apply(v[127:64], v[63:0], EDGE_CNT[e], refShift(v, int'(EDGE_CNT[e])));
      end
    end

    // random counts
    for (int n = 0; n < 300; n++) begin
      v = {$urandom, $urandom, $urandom, $urandom};
      if (n % 3 == 0) v = v >> ($urandom % 128);
      c = 8'($urandom);
      apply(v[127:64], v[63:0], c, refShift(v, int'(c)));
    end

    // R6: a single set bit survives any count
    apply(64'h0, 64'h1, 8'd200, {127'b0, 1'b1});

    // mid-run reset with validIn high clears valid (R8)
    @(negedge clk);
    validIn = 1'b1; rst = 1'b1;
    @(negedge clk);
    chk("R8", "valid after mid-run reset", {127'b0, validOut}, 128'd0);
    rst = 1'b0; validIn = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule